// File: doc/BRIEF.md
# Continuous-Phase Fast FSK Tone Modulator

This block turns a serial bit stream into a digital fast FSK (minimum shift keying) waveform. It runs from a crystal-derived master clock of 3.6864 MHz or 7.3728 MHz, divides it down to a sample rate, and produces its own transmit bit clock. The send-data and preamble-select pins are latched once per bit, at the rising edge of that bit clock. Each bit then drives a phase accumulator that moves at the mark step for a one or at the space step for a zero. The accumulator is never reset between bits. A quarter-wave sine table turns the accumulator phase into signed 8-bit samples.

Two pins set the bit rate. A third pin chooses the sine variant, where every bit starts at 0 or 180 degrees, or the cosine variant, where every bit starts at 90 or 270 degrees. While the preamble select is latched high, the send-data pin has no effect and the block transmits alternating zeros and ones.

Samples leave through a valid/ready port. The tone time base never stalls. A sample stays on the port, with valid high, until it is accepted or until the next sample replaces it. A consumer that holds ready low for longer than one sample interval therefore loses samples.

Top module: `msk_tone_gen`

## Requirements
- R1: The pair {mclk_sel, rate_fast} selects the bit rate: 00 gives 600 bps, 01 and 10 give 1200 bps, and 11 gives 2400 bps. The bit clock period is the sample divider times the samples per bit. The default sample dividers are 512, 256, 512 and 384 master clocks for the four codes, in that order.
- R2: bit_clk rises at the start of each bit and stays high for the first half of the bit's samples. send_data and preamble are latched at that rise.
- R3: Exactly one sample is produced every sample-divider master clocks. There are 8 samples per bit at 2400 bps and 12 samples per bit at the other rates, so the sample rate is 8 times the space tone.
- R4: A latched 1 uses the mark tone and a latched 0 uses the space tone. At 2400 bps these are 1200 Hz and 2400 Hz, which is 22.5 and 45 degrees per sample. At 1200 bps and 600 bps the tones are equal to and 1.5 times the bit rate, which is 30 and 45 degrees per sample.
- R5: Each sample is round(127·sin θ), within 1 LSB, in 8-bit two's complement, where θ is the accumulated phase.
- R6: Phase is continuous. The phase of a sample is the start phase plus the sum of the steps of all earlier samples since reset, taken modulo 360 degrees.
- R7: With sine_sel high at reset, the first sample of every bit has phase 0 or 180 degrees, so its value is 0. With sine_sel low, that phase is 90 or 270 degrees, so its value is +127 or -127.
- R8: A bit latched with preamble high ignores send_data. A run of such bits alternates 0, 1, 0, ..., beginning with 0 after reset or after any bit latched with preamble low.
- R9: smp_valid goes high in the cycle after each sample tick. While smp_ready is low, smp_valid and smp_data hold. A cycle with smp_ready high accepts the sample, and smp_valid then drops unless a new sample arrives in that same cycle.
- R10: A new sample replaces a pending sample that was not accepted, and smp_valid stays high.
- R11: During reset, smp_valid and bit_clk are low. The first sample after reset is the start phase of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset; samples sine_sel for the start phase |
| mclk_sel | input | 1 | Master clock frequency select (1 = 7.3728 MHz); held steady outside reset |
| rate_fast | input | 1 | Higher of the two rates for the chosen master clock; held steady outside reset |
| sine_sel | input | 1 | 1 = sine variant, 0 = cosine variant |
| send_data | input | 1 | Serial bit to transmit, latched at bit start |
| preamble | input | 1 | Preamble request, latched at bit start |
| bit_clk | output | 1 | Generated transmit bit clock |
| smp_data | output | 8 | Signed sample |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Consumer accepts the sample |

## Verification
The hardest condition to reach is the phase relation across many bit boundaries under mixed tones and preamble runs. An accumulator that drifts by one step only shows up after the mark and space steps have added up over several bits. A small offset in the start phase shows up only at the first sample of each bit. The bench therefore runs every rate code in both variants over many bits. It draws send data and preamble requests from a seeded random source, and it adds directed runs of all-space, all-mark and all-preamble bits. Each sample is checked against a phase model kept in the bench. That model advances on a fixed sample grid, even while random back-pressure hides samples from the port, so overwritten samples and held samples are still predicted.

// File: rtl/msk_pkg.sv
package msk_pkg;
  localparam int CIRCLE        = 384;
  localparam int QTR           = CIRCLE / 4;
  localparam int PH_W          = $clog2(CIRCLE);
  localparam int IDX_W         = $clog2(QTR + 1);
  localparam int SMP_W         = 8;
  localparam int AMP           = 2 ** (SMP_W - 1) - 1;
  localparam int SPB_STD       = 12;
  localparam int SPB_TOP       = 8;
  localparam int CNT_W         = $clog2(SPB_STD);
  localparam int STEP_SPACE    = CIRCLE / 8;
  localparam int STEP_MARK_STD = CIRCLE / SPB_STD;
  localparam int STEP_MARK_TOP = CIRCLE / (2 * SPB_TOP);

  typedef enum logic [1:0] {
    RATE_600    = 2'b00,
    RATE_1200_L = 2'b01,
    RATE_1200_H = 2'b10,
    RATE_2400   = 2'b11
  } rate_e;

  // Rational sine estimate for one quarter wave, rounded to the output scale.
  // The angle in degrees times 16 is u; the estimate is 4x(180-x)/(40500-x(180-x)).
  function automatic logic [SMP_W-2:0] quarter_mag(input int idx);
    longint u, p, d, n;
    u = longint'(idx) * 1440 / longint'(QTR);
    p = u * (2880 - u);
    d = 64'sd10368000 - p;
    n = (longint'(AMP) * 8 * p + d) / (2 * d);
    return n[SMP_W-2:0];
  endfunction
endpackage

// File: rtl/msk_timebase.sv
module msk_timebase
  import msk_pkg::*;
#(
  parameter int DIV_600     = 512,
  parameter int DIV_1200_L  = 256,
  parameter int DIV_1200_H  = 512,
  parameter int DIV_2400    = 384
) (
  input  logic  clk,
  input  logic  rst_n,
  input  rate_e rate,
  input  logic  send_bit,
  input  logic  pre_sel,
  output logic  tick,
  output logic  bit_start,
  output logic  bit_now,
  output logic  top_rate,
  output logic  st
);
  localparam int DIV_MAX_A = (DIV_600 > DIV_1200_L) ? DIV_600 : DIV_1200_L;
  localparam int DIV_MAX_B = (DIV_1200_H > DIV_2400) ? DIV_1200_H : DIV_2400;
  localparam int DIV_MAX   = (DIV_MAX_A > DIV_MAX_B) ? DIV_MAX_A : DIV_MAX_B;
  localparam int DIV_W     = (DIV_MAX < 2) ? 1 : $clog2(DIV_MAX);

  logic [DIV_W-1:0] pre_cnt, div_m1;
  logic [CNT_W-1:0] smp_cnt, cnt_nx, spb_m1, half;
  logic             started, cur_bit, alt, new_bit;

  always_comb begin
    unique case (rate)
      RATE_600:    div_m1 = DIV_W'(DIV_600 - 1);
      RATE_1200_L: div_m1 = DIV_W'(DIV_1200_L - 1);
      RATE_1200_H: div_m1 = DIV_W'(DIV_1200_H - 1);
      default:     div_m1 = DIV_W'(DIV_2400 - 1);
    endcase
  end

  assign top_rate  = (rate == RATE_2400);
  assign spb_m1    = top_rate ? CNT_W'(SPB_TOP - 1) : CNT_W'(SPB_STD - 1);
  assign half      = top_rate ? CNT_W'(SPB_TOP / 2) : CNT_W'(SPB_STD / 2);
  assign tick      = (pre_cnt == div_m1);
  assign bit_start = tick && (!started || smp_cnt == spb_m1);
  assign cnt_nx    = bit_start ? '0 : smp_cnt + 1'b1;
  assign new_bit   = pre_sel ? alt : send_bit;
  assign bit_now   = bit_start ? new_bit : cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      smp_cnt <= '0;
      started <= 1'b0;
      cur_bit <= 1'b0;
      alt     <= 1'b0;
      st      <= 1'b0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) begin
        started <= 1'b1;
        smp_cnt <= cnt_nx;
        st      <= (cnt_nx < half);
        if (bit_start) begin
          cur_bit <= new_bit;
          alt     <= pre_sel ? ~alt : 1'b0;
        end
      end
    end
  end

  // R3: the sample index never leaves the bit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    smp_cnt <= spb_m1);
  // R2: the bit clock rises only where a bit was started
  a_r2_st_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st) |-> $past(bit_start));
  // R3: the prescaler stays inside the selected period
  a_r3_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= div_m1);
endmodule

// File: rtl/msk_phase.sv
module msk_phase
  import msk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sine_sel,
  input  logic            tick,
  input  logic            bit_start,
  input  logic            bit_now,
  input  logic            top_rate,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] start_off, step, nxt;
  logic [PH_W:0]   sum;

  always_comb begin
    if (!bit_now)      step = PH_W'(STEP_SPACE);
    else if (top_rate) step = PH_W'(STEP_MARK_TOP);
    else               step = PH_W'(STEP_MARK_STD);
    sum = {1'b0, phase} + {1'b0, step};
    if (sum >= (PH_W+1)'(CIRCLE)) nxt = PH_W'(sum - (PH_W+1)'(CIRCLE));
    else                          nxt = sum[PH_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= sine_sel ? '0 : PH_W'(QTR);
      start_off <= sine_sel ? '0 : PH_W'(QTR);
    end else if (tick) begin
      phase <= nxt;
    end
  end

  // R7: every bit begins on the variant's pair of angles
  a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && bit_start) |-> (phase == start_off || phase == start_off + PH_W'(CIRCLE / 2)));
  // R6: the accumulator stays inside one turn
  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PH_W'(CIRCLE));
  // R6: phase moves only on sample ticks
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));
endmodule

// File: rtl/msk_sine_rom.sv
module msk_sine_rom
  import msk_pkg::*;
(
  input  logic [PH_W-1:0]         phase,
  output logic signed [SMP_W-1:0] sample
);
  logic [SMP_W-2:0] mag_tab [0:QTR];
  logic [SMP_W-2:0] mag;
  logic [1:0]       quad;
  logic [PH_W-1:0]  off;
  logic [IDX_W-1:0] idx;

  for (genvar i = 0; i <= QTR; i++) begin : g_tab
    assign mag_tab[i] = quarter_mag(i);
  end

  always_comb begin
    if (phase < PH_W'(QTR)) begin
      quad = 2'd0; off = phase;
    end else if (phase < PH_W'(2 * QTR)) begin
      quad = 2'd1; off = phase - PH_W'(QTR);
    end else if (phase < PH_W'(3 * QTR)) begin
      quad = 2'd2; off = phase - PH_W'(2 * QTR);
    end else begin
      quad = 2'd3; off = phase - PH_W'(3 * QTR);
    end
    idx    = quad[0] ? IDX_W'(PH_W'(QTR) - off) : IDX_W'(off);
    mag    = mag_tab[idx];
    sample = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end
endmodule

// File: rtl/msk_sample_port.sv
module msk_sample_port
  import msk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic signed [SMP_W-1:0] din,
  input  logic                    ready,
  output logic                    valid,
  output logic signed [SMP_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (tick) begin
      valid <= 1'b1;
      data  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R9: an unaccepted sample holds until the next tick
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !tick) |=> (valid && $stable(data)));
  // R9: acceptance clears valid when no new sample arrives
  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !tick) |=> !valid);
  // R10: a tick always presents a sample, pending or not
  a_r10_replace: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> valid);
endmodule

// File: rtl/msk_tone_gen.sv
module msk_tone_gen
  import msk_pkg::*;
#(
  parameter int DIV_600    = 512,
  parameter int DIV_1200_L = 256,
  parameter int DIV_1200_H = 512,
  parameter int DIV_2400   = 384
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mclk_sel,
  input  logic                    rate_fast,
  input  logic                    sine_sel,
  input  logic                    send_data,
  input  logic                    preamble,
  output logic                    bit_clk,
  output logic signed [SMP_W-1:0] smp_data,
  output logic                    smp_valid,
  input  logic                    smp_ready
);
  rate_e                    rate;
  logic                     tick, bit_start, bit_now, top_rate;
  logic [PH_W-1:0]          phase;
  logic signed [SMP_W-1:0]  sample;

  assign rate = rate_e'({mclk_sel, rate_fast});

  msk_timebase #(
    .DIV_600(DIV_600), .DIV_1200_L(DIV_1200_L),
    .DIV_1200_H(DIV_1200_H), .DIV_2400(DIV_2400)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .rate(rate), .send_bit(send_data),
    .pre_sel(preamble), .tick(tick), .bit_start(bit_start),
    .bit_now(bit_now), .top_rate(top_rate), .st(bit_clk)
  );

  msk_phase u_ph (
    .clk(clk), .rst_n(rst_n), .sine_sel(sine_sel), .tick(tick),
    .bit_start(bit_start), .bit_now(bit_now), .top_rate(top_rate),
    .phase(phase)
  );

  msk_sine_rom u_rom (.phase(phase), .sample(sample));

  msk_sample_port u_out (
    .clk(clk), .rst_n(rst_n), .tick(tick), .din(sample),
    .ready(smp_ready), .valid(smp_valid), .data(smp_data)
  );
endmodule

// File: tb/sim_msk_tone_gen.sv
module sim_msk_tone_gen;
  localparam int CLK_PERIOD = 10;
  localparam int D600 = 8, D1200L = 4, D1200H = 8, D2400 = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mclk_sel = 1'b0, rate_fast = 1'b0, sine_sel = 1'b1;
  logic send_data = 1'b0, preamble = 1'b0, smp_ready = 1'b1;
  logic bit_clk, smp_valid;
  logic signed [7:0] smp_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  msk_tone_gen #(.DIV_600(D600), .DIV_1200_L(D1200L), .DIV_1200_H(D1200H), .DIV_2400(D2400)) u0 (
    .clk(clk), .rst_n(rst_n), .mclk_sel(mclk_sel), .rate_fast(rate_fast),
    .sine_sel(sine_sel), .send_data(send_data), .preamble(preamble),
    .bit_clk(bit_clk), .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: actual no end of run, expected end of run");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp_v, input int tol);
    int d;
    checks++;
    d = act - exp_v;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int exp_sample(input int ph);
    real r;
    r = 127.0 * $sin(6.283185307179586 * real'(ph) / 384.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(0.5 - r);
  endfunction

  function automatic int step_of(input bit b, input bit top);
    if (!b) return 48;   // space: 45 degrees
    return top ? 24 : 32; // mark: 22.5 or 30 degrees
  endfunction

  function automatic int div_of(input bit mcs, input bit fast);
    case ({mcs, fast})
      2'b00: return D600;
      2'b01: return D1200L;
      2'b10: return D1200H;
      default: return D2400;
    endcase
  endfunction

  // sd_mode: 0 random, 1 all zero, 2 all one; pre_mode: 0 none, 1 random, 2 always
  task automatic run_cfg(input bit mcs, input bit fast, input bit sine, input int nbits,
                         input int sd_mode, input int pre_mode, input bit bp);
    bit effb [0:63];
    bit ispre [0:63];
    bit alt, top, pr, sd, pv, pr_rdy;
    int div, spb, cyc, k, off, ph, last_rise, j, pdat, nsamp;
    string tag;
    top = mcs && fast;
    spb = top ? 8 : 12;
    div = div_of(mcs, fast);
    nsamp = nbits * spb;

    @(negedge clk);
    rst_n = 1'b0; mclk_sel = mcs; rate_fast = fast; sine_sel = sine; smp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 valid in reset", int'(smp_valid), 0, 0);
    chk("R11 bit_clk in reset", int'(bit_clk), 0, 0);

    alt = 1'b0;
    pr = (pre_mode == 2) || (pre_mode == 1 && ($urandom % 4 == 0));
    sd = (sd_mode == 0) ? 1'($urandom % 2) : (sd_mode == 2);
    effb[0] = pr ? alt : sd; ispre[0] = pr; alt = pr ? ~alt : 1'b0;
    send_data = sd; preamble = pr;
    rst_n = 1'b1;

    cyc = -1; ph = sine ? 0 : 96; last_rise = 0; pv = 1'b0; pr_rdy = 1'b1; pdat = 0;
    while (cyc < nsamp * div - 1) begin
      @(negedge clk);
      if (cyc < 0 && smp_valid) cyc = 0;
      else if (cyc >= 0) cyc++;
      if (cyc >= 0) begin
        off = cyc % div;
        k = cyc / div;
        if (off == 0) begin
          if (pv && !pr_rdy) chk("R10 pending replaced, valid", int'(smp_valid), 1, 0);
          else chk("R3 sample tick valid", int'(smp_valid), 1, 0);
          if (ispre[k / spb]) tag = "R8 preamble sample";
          else if (k % spb == 0) tag = "R6 bit-start sample";
          else if (k % spb % 2 == 1) tag = "R4 tone sample";
          else tag = "R5 sample value";
          chk($sformatf("%s k=%0d", tag, k), int'(smp_data), exp_sample(ph), 1);
          if (k % spb == 0) begin
            chk($sformatf("R7 aligned start k=%0d", k), int'(smp_data), exp_sample(ph), 0);
            chk("R2 bit_clk high at bit start", int'(bit_clk), 1, 0);
            if (k > 0) chk("R1 bit clock period", cyc - last_rise, div * spb, 0);
            last_rise = cyc;
            j = k / spb + 1;
            pr = (pre_mode == 2) || (pre_mode == 1 && ($urandom % 4 == 0));
            sd = (sd_mode == 0) ? 1'($urandom % 2) : (sd_mode == 2);
            effb[j] = pr ? alt : sd; ispre[j] = pr; alt = pr ? ~alt : 1'b0;
            send_data = sd; preamble = pr;
          end
          if (k % spb == spb / 2) chk("R2 bit_clk low in second half", int'(bit_clk), 0, 0);
          ph = (ph + step_of(effb[k / spb], top)) % 384;
        end else begin
          if (pv && pr_rdy) chk("R9 valid drops after accept", int'(smp_valid), 0, 0);
          else if (pv) begin
            chk("R9 valid held", int'(smp_valid), 1, 0);
            chk("R9 data held", int'(smp_data), pdat, 0);
          end else chk("R9 no valid between samples", int'(smp_valid), 0, 0);
        end
        smp_ready = bp ? 1'($urandom % 3 == 0) : 1'b1;
        pv = smp_valid; pr_rdy = smp_ready; pdat = int'(smp_data);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd7741));
    run_cfg(1, 1, 1, 16, 0, 1, 0);
    run_cfg(1, 1, 0, 12, 0, 2, 0);
    run_cfg(1, 0, 1, 14, 0, 1, 1);
    run_cfg(1, 0, 0, 14, 0, 1, 0);
    run_cfg(0, 1, 1, 14, 0, 1, 1);
    run_cfg(0, 1, 0, 14, 0, 0, 0);
    run_cfg(0, 0, 1, 12, 0, 1, 0);
    run_cfg(0, 0, 0, 12, 0, 1, 1);
    run_cfg(1, 1, 0, 10, 1, 0, 0);
    run_cfg(1, 1, 1, 10, 2, 0, 0);
    run_cfg(0, 0, 1, 10, 2, 0, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule